// File: doc/BRIEF.md
# DRAM Refresh Interval Timer

This block sets the pace of auto-refresh for a DRAM controller. Software writes a 14-bit reload count into a configuration word. While the timer is enabled it counts controller clock cycles down from that count. When the count runs out it raises a refresh request. The request stays high until the command sequencer acknowledges it. On the acknowledge the counter reloads and the next interval starts.

The reload count is worked out off-chip as the number of clocks in one refresh period, less the cycles spent on row activation and precharge. For example, at 200 MHz a 7.8 µs period with 9 activate cycles and 3 precharge cycles gives 1560 − 12 = 1548 (0x60C).

A reload count of zero is an illegal setting. It is flagged and no requests are issued. The block also drives the DRAM clock-enable. Both the hard reset and the soft reset force clock-enable low with no clock edge needed.

Top module: `dram_refresh_timer`

## Requirements
- R1: During and after hard reset (`rst_n` low), `refresh_req_o` and `zero_reload_o` are 0 and the stored reload count is 0.
- R2: `dram_cke_o` is 0 combinationally whenever `rst_n` is low or `soft_rst_i` is high. It returns to 1 on the second rising clock edge after both have been released (CKE_DELAY = 2).
- R3: A write (`cfg_we_i` high at a rising edge) stores bits 13..0 of `cfg_wdata_i` as the reload count N. All other bits of the word are ignored.
- R4: If `enable_i` is high and N is nonzero at a rising edge while the timer is idle, N is loaded at that edge. `refresh_req_o` rises after exactly N further rising edges. N may be anything from 1 to 0x3FFF.
- R5: Once `refresh_req_o` is high, it stays high on every following cycle until `refresh_ack_i` is sampled high, provided the timer stays enabled and legal.
- R6: When `refresh_ack_i` is sampled high with `refresh_req_o` high, the request drops on the next cycle. The stored N is reloaded at that edge, and the next request rises N edges after it.
- R7: A write of a new N while the timer is counting does not change the interval in progress. It is used from the next reload on.
- R8: `zero_reload_o` equals `enable_i` AND (stored N == 0). While it is high, no request is raised, and a pending request drops on the following cycle. Writing a nonzero N later restarts the timer.
- R9: With `enable_i` low, the request drops on the next cycle and counting stops. Raising `enable_i` again starts a full interval of N edges.
- R10: `soft_rst_i` sampled high returns the timer to idle, so the request is low on the next cycle. The stored N is kept, and a full interval of N starts once `soft_rst_i` is released.
- R11: With N = 1 the request rises one edge after the load, and one edge after each acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Hard reset, active low, asynchronous |
| soft_rst_i | input | 1 | Soft reset, active high |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 32 | Configuration word; bits 13..0 hold the reload count |
| enable_i | input | 1 | Timer enable |
| refresh_ack_i | input | 1 | Acknowledge from the command sequencer |
| refresh_req_o | output | 1 | Refresh request, held until acknowledged |
| zero_reload_o | output | 1 | Illegal zero reload while enabled |
| dram_cke_o | output | 1 | DRAM clock-enable |

## Verification
The interval is measured for several kinds of reload count:
- Random counts from 1 to 80, with random junk in the upper configuration bits. These tell a correct 14-bit field from a mis-sliced one.
- The minimum of 1, which exposes any off-by-one between load and expiry.
- The 1548 example computed by a bench function, and the maximum of 0x3FFF, which catch a truncated counter.

Random acknowledge delays separate a held request from a one-cycle pulse. A write made in mid-interval, a disable in mid-interval and a soft reset in mid-interval each separate deferred from immediate reloading. A zero count written both while idle and while a request is pending checks the illegal-setting path and the recovery from it.

// File: rtl/dram_rft_pkg.sv
package dram_rft_pkg;

   typedef enum logic [1:0] {
      RFT_IDLE  = 2'd0,
      RFT_COUNT = 2'd1,
      RFT_REQ   = 2'd2
   } rft_state_e;

   localparam int RFT_CFG_W_DEFAULT    = 32;
   localparam int RFT_RELOAD_W_DEFAULT = 14;

endpackage

// File: rtl/dram_rft_cfg_reg.sv
module dram_rft_cfg_reg #(
   parameter int CFG_W        = 32,
   parameter int RELOAD_W     = 14,
   parameter int RELOAD_LSB   = 0,
   parameter int RESET_RELOAD = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [CFG_W-1:0]    wdata,
   output logic [RELOAD_W-1:0] reload,
   output logic                reload_zero
);

   localparam logic [CFG_W-1:0] FIELD_MASK =
      CFG_W'(((64'd1 << RELOAD_W) - 64'd1) << RELOAD_LSB);

   logic [RELOAD_W-1:0] field_q;
   logic                unused_cfg_bits;

   assign unused_cfg_bits = ^(wdata & ~FIELD_MASK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         field_q <= RELOAD_W'(RESET_RELOAD);
      end else if (we) begin
         field_q <= wdata[RELOAD_LSB +: RELOAD_W];
      end
   end

   assign reload      = field_q;
   assign reload_zero = (field_q == '0);

endmodule

// File: rtl/dram_rft_down_counter.sv
module dram_rft_down_counter #(
   parameter int W = 14
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic         at_one
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (dec) begin
         cnt_q <= cnt_q - W'(1);
      end
   end

   assign at_one = (cnt_q == W'(1));

endmodule

// File: rtl/dram_rft_ctrl.sv
module dram_rft_ctrl
   import dram_rft_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic soft_rst,
   input  logic enable,
   input  logic reload_zero,
   input  logic at_one,
   input  logic ack,
   output logic load,
   output logic dec,
   output logic req
);

   rft_state_e state_q, state_d;
   logic       run;

   assign run = enable && !reload_zero && !soft_rst;

   always_comb begin
      state_d = state_q;
      load    = 1'b0;
      dec     = 1'b0;
      unique case (state_q)
         RFT_IDLE: begin
            if (run) begin
               load    = 1'b1;
               state_d = RFT_COUNT;
            end
         end
         RFT_COUNT: begin
            if (!run) begin
               state_d = RFT_IDLE;
            end else if (at_one) begin
               state_d = RFT_REQ;
            end else begin
               dec = 1'b1;
            end
         end
         RFT_REQ: begin
            if (!run) begin
               state_d = RFT_IDLE;
            end else if (ack) begin
               load    = 1'b1;
               state_d = RFT_COUNT;
            end
         end
         default: state_d = RFT_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= RFT_IDLE;
      end else begin
         state_q <= state_d;
      end
   end

   assign req = (state_q == RFT_REQ);

endmodule

// File: rtl/dram_rft_cke.sv
module dram_rft_cke #(
   parameter int CKE_DELAY = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic soft_rst,
   output logic cke
);

   generate
      if (CKE_DELAY == 0) begin : g_direct
         assign cke = rst_n && !soft_rst;
      end else begin : g_staged
         logic [CKE_DELAY-1:0] stage_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stage_q <= '0;
            end else if (soft_rst) begin
               stage_q <= '0;
            end else begin
               stage_q <= {stage_q[CKE_DELAY-1:0], 1'b1} >> 0;
            end
         end
         assign cke = stage_q[CKE_DELAY-1] && !soft_rst;
      end
   endgenerate

endmodule

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer
   import dram_rft_pkg::*;
#(
   parameter int CFG_W        = RFT_CFG_W_DEFAULT,
   parameter int RELOAD_W     = RFT_RELOAD_W_DEFAULT,
   parameter int RELOAD_LSB   = 0,
   parameter int RESET_RELOAD = 0,
   parameter int CKE_DELAY    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst_i,
   input  logic             cfg_we_i,
   input  logic [CFG_W-1:0] cfg_wdata_i,
   input  logic             enable_i,
   input  logic             refresh_ack_i,
   output logic             refresh_req_o,
   output logic             zero_reload_o,
   output logic             dram_cke_o
);

   if (RELOAD_W < 2 || RELOAD_W > 24) begin : g_bad_width
      $error("RELOAD_W must be between 2 and 24");
   end
   if (RELOAD_LSB < 0 || RELOAD_LSB + RELOAD_W > CFG_W) begin : g_bad_field
      $error("reload field does not fit in the configuration word");
   end
   if (RESET_RELOAD < 0 || RESET_RELOAD >= (1 << RELOAD_W)) begin : g_bad_reset
      $error("RESET_RELOAD out of range for RELOAD_W");
   end
   if (CKE_DELAY < 0 || CKE_DELAY > 8) begin : g_bad_cke
      $error("CKE_DELAY must be between 0 and 8");
   end

   logic [RELOAD_W-1:0] reload;
   logic                reload_zero;
   logic                at_one;
   logic                ld;
   logic                dec;

   dram_rft_cfg_reg #(
      .CFG_W       (CFG_W),
      .RELOAD_W    (RELOAD_W),
      .RELOAD_LSB  (RELOAD_LSB),
      .RESET_RELOAD(RESET_RELOAD)
   ) cfg_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .we         (cfg_we_i),
      .wdata      (cfg_wdata_i),
      .reload     (reload),
      .reload_zero(reload_zero)
   );

   dram_rft_down_counter #(
      .W(RELOAD_W)
   ) cnt_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (ld),
      .load_val(reload),
      .dec     (dec),
      .at_one  (at_one)
   );

   dram_rft_ctrl ctrl_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .soft_rst   (soft_rst_i),
      .enable     (enable_i),
      .reload_zero(reload_zero),
      .at_one     (at_one),
      .ack        (refresh_ack_i),
      .load       (ld),
      .dec        (dec),
      .req        (refresh_req_o)
   );

   dram_rft_cke #(
      .CKE_DELAY(CKE_DELAY)
   ) cke_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .soft_rst(soft_rst_i),
      .cke     (dram_cke_o)
   );

   assign zero_reload_o = enable_i && reload_zero;

endmodule

// File: rtl/dram_refresh_timer_chk.sv
module dram_refresh_timer_chk (
   input logic clk,
   input logic rst_n,
   input logic soft_rst_i,
   input logic enable_i,
   input logic refresh_ack_i,
   input logic refresh_req_o,
   input logic zero_reload_o,
   input logic dram_cke_o
);

   assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (refresh_req_o && !refresh_ack_i && enable_i && !zero_reload_o && !soft_rst_i)
      |=> refresh_req_o);

   assert_ack_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (refresh_req_o && refresh_ack_i) |=> !refresh_req_o);

   assert_zero_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      zero_reload_o |=> !refresh_req_o);

   assert_disable_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !enable_i |=> !refresh_req_o);

   assert_soft_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst_i |=> !refresh_req_o);

   always_comb begin
      if (!rst_n || soft_rst_i) begin
         assert_cke_low_R2: assert (!dram_cke_o);
      end
   end

endmodule

bind dram_refresh_timer dram_refresh_timer_chk chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .soft_rst_i   (soft_rst_i),
   .enable_i     (enable_i),
   .refresh_ack_i(refresh_ack_i),
   .refresh_req_o(refresh_req_o),
   .zero_reload_o(zero_reload_o),
   .dram_cke_o   (dram_cke_o)
);

// File: tb/dram_refresh_timer_tb_top.sv
module dram_refresh_timer_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int CW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          soft_rst_i = 1'b0;
   logic          cfg_we_i = 1'b0;
   logic [CW-1:0] cfg_wdata_i = '0;
   logic          enable_i = 1'b0;
   logic          refresh_ack_i = 1'b0;
   logic          refresh_req_o;
   logic          zero_reload_o;
   logic          dram_cke_o;

   int  total = 0;
   int  bad = 0;
   bit  done = 0;

   dram_refresh_timer dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .soft_rst_i   (soft_rst_i),
      .cfg_we_i     (cfg_we_i),
      .cfg_wdata_i  (cfg_wdata_i),
      .enable_i     (enable_i),
      .refresh_ack_i(refresh_ack_i),
      .refresh_req_o(refresh_req_o),
      .zero_reload_o(zero_reload_o),
      .dram_cke_o   (dram_cke_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // reload = clocks per period minus activate and precharge cycles
   function automatic int calc_reload(int clk_mhz, int period_ns, int t_act, int t_pre);
      return (clk_mhz * period_ns) / 1000 - (t_act + t_pre);
   endfunction

   function automatic int field_of(logic [CW-1:0] w);
      return int'(w[13:0]);
   endfunction

   // negedges from the enabling negedge to the first one showing the request
   function automatic int first_gap(int n);
      return n + 1;
   endfunction

   task automatic chk(bit ok, string rq, string what, longint act, longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
      end
   endtask

   task automatic write_cfg(logic [CW-1:0] v);
      @(negedge clk);
      cfg_we_i = 1'b1;
      cfg_wdata_i = v;
      @(negedge clk);
      cfg_we_i = 1'b0;
   endtask

   task automatic wait_req(int limit, output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!refresh_req_o && n < limit);
   endtask

   task automatic do_ack(string rq);
      refresh_ack_i = 1'b1;
      @(negedge clk);
      refresh_ack_i = 1'b0;
      chk(refresh_req_o == 1'b0, rq, "request after ack", refresh_req_o, 0);
   endtask

   task automatic start_and_measure(int n, string rq);
      int m;
      enable_i = 1'b1;
      wait_req(first_gap(n) + 5, m);
      chk(m == first_gap(n), rq, "first interval", m, first_gap(n));
   endtask

   task automatic next_interval(int n, string rq);
      int m;
      wait_req(n + 5, m);
      chk(m == n, rq, "interval after ack", m, n);
   endtask

   task automatic stop_timer();
      enable_i = 1'b0;
      @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int n;
      int m;
      logic [CW-1:0] w;
      void'($urandom(32'h5EED_1234));

      // R1, R2: reset state
      #1;
      chk(dram_cke_o == 1'b0, "R2", "cke in hard reset", dram_cke_o, 0);
      repeat (3) @(negedge clk);
      chk(refresh_req_o == 1'b0, "R1", "req in reset", refresh_req_o, 0);
      chk(zero_reload_o == 1'b0, "R1", "zero flag in reset", zero_reload_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(dram_cke_o == 1'b0, "R2", "cke one edge after reset", dram_cke_o, 0);
      @(negedge clk);
      chk(dram_cke_o == 1'b1, "R2", "cke two edges after reset", dram_cke_o, 1);

      // R8 / R1: reload is zero out of reset
      enable_i = 1'b1;
      #1;
      chk(zero_reload_o == 1'b1, "R8", "zero flag with reset reload", zero_reload_o, 1);
      n = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (refresh_req_o) n++;
      end
      chk(n == 0, "R8", "requests with zero reload", n, 0);
      enable_i = 1'b0;
      #1;
      chk(zero_reload_o == 1'b0, "R8", "zero flag when disabled", zero_reload_o, 0);

      // R11: minimum reload
      write_cfg(32'd1);
      start_and_measure(1, "R11");
      do_ack("R11");
      next_interval(1, "R11");
      do_ack("R11");
      stop_timer();

      // R4, R5, R6: worked example
      n = calc_reload(200, 7800, 9, 3);
      chk(n == 1548, "R4", "computed reload", n, 1548);
      write_cfg(CW'(n));
      start_and_measure(n, "R4");
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         chk(refresh_req_o == 1'b1, "R5", "request held", refresh_req_o, 1);
      end
      do_ack("R6");
      next_interval(n, "R6");
      do_ack("R6");
      stop_timer();

      // R3: upper bits ignored
      w = 32'hABCD_C000 | 32'd25;
      write_cfg(w);
      start_and_measure(field_of(w), "R3");
      do_ack("R3");
      stop_timer();

      // R7: write during count is deferred
      write_cfg(32'd40);
      enable_i = 1'b1;
      repeat (10) @(negedge clk);
      write_cfg(32'd20);
      wait_req(60, m);
      chk(12 + m == first_gap(40), "R7", "interval after mid-count write", 12 + m, first_gap(40));
      do_ack("R7");
      next_interval(20, "R7");
      do_ack("R7");
      stop_timer();

      // R9: disable in mid-count and while requesting
      write_cfg(32'd30);
      enable_i = 1'b1;
      repeat (10) @(negedge clk);
      enable_i = 1'b0;
      n = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (refresh_req_o) n++;
      end
      chk(n == 0, "R9", "requests while disabled", n, 0);
      start_and_measure(30, "R9");
      enable_i = 1'b0;
      @(negedge clk);
      chk(refresh_req_o == 1'b0, "R9", "request after disable", refresh_req_o, 1'b0);
      @(negedge clk);

      // R10: soft reset in mid-count
      enable_i = 1'b1;
      repeat (5) @(negedge clk);
      soft_rst_i = 1'b1;
      #1;
      chk(dram_cke_o == 1'b0, "R2", "cke in soft reset", dram_cke_o, 0);
      @(negedge clk);
      chk(refresh_req_o == 1'b0, "R10", "request in soft reset", refresh_req_o, 0);
      soft_rst_i = 1'b0;
      wait_req(40, m);
      chk(m == first_gap(30), "R10", "interval after soft reset", m, first_gap(30));
      chk(dram_cke_o == 1'b1, "R2", "cke after soft reset", dram_cke_o, 1);

      // R8: zero written while a request is pending
      write_cfg(32'd0);
      chk(zero_reload_o == 1'b1, "R8", "zero flag after write", zero_reload_o, 1);
      @(negedge clk);
      chk(refresh_req_o == 1'b0, "R8", "pending request dropped", refresh_req_o, 0);
      write_cfg(32'd15);
      chk(zero_reload_o == 1'b0, "R8", "zero flag after nonzero", zero_reload_o, 0);
      wait_req(30, m);
      chk(m == first_gap(15), "R8", "interval after recovery", m, first_gap(15));
      do_ack("R8");
      stop_timer();

      // R4, R5, R6, R3: random reloads and acknowledge delays
      for (int it = 0; it < 40; it++) begin
         n = 1 + int'($urandom_range(79));
         w = ($urandom() & 32'hFFFF_C000) | CW'(n);
         write_cfg(w);
         start_and_measure(field_of(w), "R4");
         for (int k = 0; k < 3; k++) begin
            m = int'($urandom_range(4));
            for (int d = 0; d < m; d++) begin
               @(negedge clk);
               chk(refresh_req_o == 1'b1, "R5", "random hold", refresh_req_o, 1);
            end
            do_ack("R6");
            next_interval(n, "R6");
         end
         do_ack("R6");
         stop_timer();
      end

      // R4: largest reload
      write_cfg(32'h0000_3FFF);
      start_and_measure(16383, "R4");
      do_ack("R4");
      stop_timer();

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule